// File: doc/BRIEF.md
# Keyed Watchdog and Interval Timer

The block is a single-register watchdog. A 16-bit control word, written through a plain write strobe and data bus, sets four things. It picks which of four tick-enable strobes the counter follows. It picks one of eight power-of-two expiry intervals. It chooses whether expiry resets the system or raises an interrupt. It can also freeze or clear the counter. Each write must carry the key 0x5A in its upper byte. A write with any other key leaves the configuration as it was and requests a system reset.

In watchdog mode, software writes a clear command at regular intervals. If it stops doing so, the counter reaches the selected interval and the block emits a one-cycle reset request. In interval mode the same counter restarts on each expiry and sets a sticky interrupt flag, which is cleared by a separate strobe. The tick sources are enable strobes in the block's own clock domain.

Top module: `wdt_keyed`

## Requirements
- R1: A write whose bits 15:8 are not 0x5A drives `sys_rst_req` high in the cycle after the write and leaves the readable configuration unchanged.
- R2: A write with key 0x5A stores interval code in bits 2:0, mode in bit 4 (0 watchdog, 1 interval), source in bits 6:5 and hold in bit 7; these read back at the same positions.
- R3: Reads return 0x69 in bits 15:8 and 0 in bit 3, whatever was written there.
- R4: After reset the register reads 0x6904 (watchdog mode, source 0, interval code 4, hold 0), the counter is zero and both outputs are low.
- R5: Interval codes 0..7 select 2^31, 2^27, 2^23, 2^19, 2^15, 2^13, 2^9 and 2^6 ticks; expiry occurs on the tick that brings the count to that value.
- R6: A keyed write with bit 3 set forces the counter to zero; with bit 3 clear the count is kept.
- R7: Only the strobe `tick_src[n]`, where n is the source code, advances the counter.
- R8: While hold is 1 the counter ignores all ticks and no expiry occurs.
- R9: In watchdog mode expiry gives a one-cycle `sys_rst_req` pulse, leaves `irq_flag` alone, and restarts the count from zero.
- R10: In interval mode expiry sets `irq_flag`, does not raise `sys_rst_req`, and restarts the count from zero.
- R11: `irq_flag` stays set until `irq_clr` is strobed; if an expiry and `irq_clr` fall in the same cycle, the flag ends set.
- R12: A write that changes the interval and sets bit 3 counts the new interval from zero, never against the old count.
- R13: A clear command and a tick in the same cycle leave the counter at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 16 | Write data: key in 15:8, control in 7:0 |
| rd_data | output | 16 | Register read value |
| tick_src | input | 4 | Tick-enable strobes, one per source |
| irq_clr | input | 1 | Clears the interrupt flag |
| sys_rst_req | output | 1 | System reset request pulse |
| irq_flag | output | 1 | Sticky interval-expiry flag |

## Verification
The bench loads a large count under a long interval and then rewrites a short interval with the clear bit set. A design that compared the stale count against the new limit would fire a reset on the next tick. It puts a clear command and a tick in the same cycle, where a design that let the tick win would expire one tick early. It feeds ticks on the three unselected sources, strobes ticks under hold, and issues a wrong-key write. In those cases a careless design counts foreign strobes, counts while frozen, or takes the bad configuration. It lands `irq_clr` on the expiry cycle, where a clear-priority design would lose the interrupt.

// File: rtl/wdt_keyed.sv
module wdt_keyed #(
  parameter int          CNT_W   = 32,
  parameter logic [7:0]  WR_KEY  = 8'h5A,
  parameter logic [7:0]  RD_KEY  = 8'h69,
  parameter logic [7:0]  CFG_RST = 8'h04
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [15:0] wr_data,
  output logic [15:0] rd_data,
  input  logic [3:0]  tick_src,
  input  logic        irq_clr,
  output logic        sys_rst_req,
  output logic        irq_flag
);
  localparam int SHIFT_W = $clog2(CNT_W);

  logic [7:0]       cfg;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] limit;
  logic [SHIFT_W-1:0] tap;

  wire key_ok  = (wr_data[15:8] == WR_KEY);
  wire wr_good = wr_en && key_ok;
  wire wr_bad  = wr_en && !key_ok;
  wire clr_now = wr_good && wr_data[3];

  wire       hold  = cfg[7];
  wire [1:0] src   = cfg[6:5];
  wire       ivl   = cfg[4];
  wire [2:0] ivsel = cfg[2:0];

  always_comb begin
    case (ivsel)
      3'd0:    tap = SHIFT_W'(31);
      3'd1:    tap = SHIFT_W'(27);
      3'd2:    tap = SHIFT_W'(23);
      3'd3:    tap = SHIFT_W'(19);
      3'd4:    tap = SHIFT_W'(15);
      3'd5:    tap = SHIFT_W'(13);
      3'd6:    tap = SHIFT_W'(9);
      default: tap = SHIFT_W'(6);
    endcase
  end

  assign limit = {{(CNT_W-1){1'b0}}, 1'b1} << tap;

  wire              tick    = !hold && tick_src[src];
  wire [CNT_W-1:0]  cnt_inc = cnt + CNT_W'(1);
  wire              fire    = tick && (cnt_inc >= limit) && !clr_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cfg <= CFG_RST;
    else if (wr_good) cfg <= {wr_data[7:4], 1'b0, wr_data[2:0]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (clr_now || fire)  cnt <= '0;
    else if (tick)             cnt <= cnt_inc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sys_rst_req <= 1'b0;
      irq_flag    <= 1'b0;
    end else begin
      sys_rst_req <= wr_bad || (fire && !ivl);
      if (fire && ivl)  irq_flag <= 1'b1;
      else if (irq_clr) irq_flag <= 1'b0;
    end
  end

  assign rd_data = {RD_KEY, cfg[7:4], 1'b0, cfg[2:0]};
endmodule

module wdt_keyed_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [15:0] wr_data,
  input logic [15:0] rd_data,
  input logic        irq_clr,
  input logic        sys_rst_req,
  input logic        irq_flag
);
  AST_BAD_KEY_RST: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_data[15:8] != 8'h5A |=> sys_rst_req); // R1
  AST_BAD_KEY_CFG: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_data[15:8] != 8'h5A |=> $stable(rd_data)); // R1
  AST_GOOD_WR_CFG: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_data[15:8] == 8'h5A |=> rd_data[7:4] == $past(wr_data[7:4]) && rd_data[2:0] == $past(wr_data[2:0])); // R2
  AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[7] && !wr_en |=> !sys_rst_req); // R8
  AST_IVL_NO_RST: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[4] && !wr_en |=> !sys_rst_req); // R10
  AST_WDOG_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_data[4] && !irq_flag |=> !irq_flag); // R9
  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    irq_flag && !irq_clr |=> irq_flag); // R11
  AST_IRQ_FALL_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_flag) |-> $past(irq_clr)); // R11
endmodule

bind wdt_keyed wdt_keyed_chk chk_i (.*);

// File: tb/wdt_keyed_tb_top.sv
module wdt_keyed_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic [3:0]  tick_src = '0;
  logic        irq_clr = 1'b0;
  wire  [15:0] rd_data;
  wire         sys_rst_req;
  wire         irq_flag;

  wdt_keyed dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .tick_src(tick_src), .irq_clr(irq_clr),
    .sys_rst_req(sys_rst_req), .irq_flag(irq_flag)
  );

  always #10 clk = ~clk;

  typedef struct {
    string       req;
    logic [15:0] rd;
    logic        rst;
    logic        irq;
  } exp_t;

  exp_t        q[$];
  int          n_run = 0;
  int          n_fail = 0;
  logic [15:0] model_rd = 16'h6904;
  bit          done = 0;

  task automatic drive(input logic we, input logic [15:0] d, input logic [3:0] tk, input logic ic);
    @(negedge clk);
    wr_en = we; wr_data = d; tick_src = tk; irq_clr = ic;
    if (we && d[15:8] == 8'h5A) model_rd = {8'h69, d[7:4], 1'b0, d[2:0]};
  endtask

  task automatic expect_next(input string req, input logic rst, input logic irq);
    exp_t e;
    e.req = req; e.rd = model_rd; e.rst = rst; e.irq = irq;
    q.push_back(e);
  endtask

  task automatic cfg_wr(input logic [7:0] lo);
    drive(1'b1, {8'h5A, lo}, 4'b0000, 1'b0);
  endtask

  task automatic run_then(input int n, input logic [3:0] tk, input string req, input logic rst, input logic irq);
    for (int i = 0; i < n; i++) drive(1'b0, 16'h0000, tk, 1'b0);
    expect_next(req, rst, irq);
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(posedge clk);
      #5;
      while (q.size() > 0) begin
        e = q.pop_front();
        n_run++;
        if (rd_data !== e.rd || sys_rst_req !== e.rst || irq_flag !== e.irq) begin
          n_fail++;
          $display("FAIL %s: rd=%h rst=%b irq=%b expected rd=%h rst=%b irq=%b",
                   e.req, rd_data, sys_rst_req, irq_flag, e.rd, e.rst, e.irq);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run + 1, n_fail);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    drive(1'b0, 16'h0000, 4'b0000, 1'b0);
    expect_next("R4 reset state", 1'b0, 1'b0);

    cfg_wr(8'hDB);
    expect_next("R2/R3 readback", 1'b0, 1'b0);

    drive(1'b1, 16'hA500, 4'b0000, 1'b0);
    expect_next("R1 bad key", 1'b1, 1'b0);
    drive(1'b0, 16'h0000, 4'b0000, 1'b0);
    expect_next("R1 pulse ends", 1'b0, 1'b0);

    cfg_wr(8'h0F);
    run_then(63, 4'b0001, "R5 code7 early", 1'b0, 1'b0);
    run_then(1,  4'b0001, "R9 watchdog expiry", 1'b1, 1'b0);
    run_then(1,  4'b0000, "R9 one-cycle pulse", 1'b0, 1'b0);

    cfg_wr(8'h2F);
    run_then(64, 4'b1101, "R7 other sources ignored", 1'b0, 1'b0);
    run_then(63, 4'b0010, "R7 source1 early", 1'b0, 1'b0);
    run_then(1,  4'b0010, "R7 source1 expiry", 1'b1, 1'b0);

    cfg_wr(8'h8F);
    run_then(100, 4'b0001, "R8 hold frozen", 1'b0, 1'b0);
    cfg_wr(8'h07);
    run_then(63, 4'b0001, "R8 count kept at zero", 1'b0, 1'b0);
    run_then(1,  4'b0001, "R8 after release", 1'b1, 1'b0);

    cfg_wr(8'h0F);
    run_then(40, 4'b0001, "R6 partial", 1'b0, 1'b0);
    cfg_wr(8'h07);
    run_then(23, 4'b0001, "R6 no-clear keeps count", 1'b0, 1'b0);
    run_then(1,  4'b0001, "R6 no-clear expiry", 1'b1, 1'b0);
    run_then(40, 4'b0001, "R9 restart from zero", 1'b0, 1'b0);
    cfg_wr(8'h0F);
    run_then(63, 4'b0001, "R6 clear zeroes", 1'b0, 1'b0);
    run_then(1,  4'b0001, "R6 clear expiry", 1'b1, 1'b0);

    run_then(30, 4'b0001, "R13 partial", 1'b0, 1'b0);
    drive(1'b1, 16'h5A0F, 4'b0001, 1'b0);
    expect_next("R13 clear with tick", 1'b0, 1'b0);
    run_then(63, 4'b0001, "R13 early", 1'b0, 1'b0);
    run_then(1,  4'b0001, "R13 expiry", 1'b1, 1'b0);

    cfg_wr(8'h0E);
    run_then(300, 4'b0001, "R12 long count", 1'b0, 1'b0);
    cfg_wr(8'h0F);
    run_then(1,  4'b0001, "R12 no stale expiry", 1'b0, 1'b0);
    run_then(62, 4'b0001, "R12 early", 1'b0, 1'b0);
    run_then(1,  4'b0001, "R12 new interval", 1'b1, 1'b0);

    cfg_wr(8'h0E);
    run_then(511, 4'b0001, "R5 code6 early", 1'b0, 1'b0);
    run_then(1,   4'b0001, "R5 code6 expiry", 1'b1, 1'b0);
    cfg_wr(8'h0D);
    run_then(8191, 4'b0001, "R5 code5 early", 1'b0, 1'b0);
    run_then(1,    4'b0001, "R5 code5 expiry", 1'b1, 1'b0);

    cfg_wr(8'h1F);
    run_then(63, 4'b0001, "R10 early", 1'b0, 1'b0);
    run_then(1,  4'b0001, "R10 interval expiry", 1'b0, 1'b1);
    run_then(10, 4'b0000, "R11 sticky", 1'b0, 1'b1);
    drive(1'b0, 16'h0000, 4'b0000, 1'b1);
    expect_next("R11 clear", 1'b0, 1'b0);
    run_then(63, 4'b0001, "R10 restart early", 1'b0, 1'b0);
    run_then(1,  4'b0001, "R10 second expiry", 1'b0, 1'b1);
    run_then(63, 4'b0001, "R11 still set", 1'b0, 1'b1);
    drive(1'b0, 16'h0000, 4'b0001, 1'b1);
    expect_next("R11 set wins over clear", 1'b0, 1'b1);
    drive(1'b0, 16'h0000, 4'b0000, 1'b1);
    expect_next("R11 clear after", 1'b0, 1'b0);

    drive(1'b0, 16'h0000, 4'b0000, 1'b0);
    repeat (3) @(posedge clk);
    #5;
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule